// File: doc/BRIEF.md
# Banked Multi-Lane Scratchpad with Conflict Replay

This block is an on-chip scratchpad shared by a group of lanes. Each request carries one word address per lane, an active mask, per-lane store data and a load/store flag. The storage is split into interleaved banks, one 32-bit word wide, so that word `w` lives in bank `w mod BANKS` at row `w / BANKS`. Lanes whose words fall in different banks are served in the same cycle.

When several active lanes of one request need different words of the same bank, the block serves them over extra passes. Lanes asking for the very same word are merged into a single access that feeds all of them, and this costs no extra pass. In each pass, every bank serves its lowest-numbered pending lane together with all pending lanes that share that lane's word. When no lane is pending, the block raises a one-cycle done pulse. With that pulse it presents the read data of all lanes and the number of passes used.

The request port has a valid/ready handshake and takes a new request only once the previous one has finished. A 16-bank, 16-lane build uses the same RTL with different parameters. Collisions are judged only inside one request, so consecutive requests never slow each other down.

Top module: `bspad_top`

## Requirements
- R1: Word address `w` maps to bank `w mod BANKS` and row `w / BANKS`. A load of `w` returns the last value stored to `w` by an earlier request.
- R2: A request whose active lanes all touch distinct banks (for example consecutive words) completes in one pass, with `rsp_done` high in the cycle after acceptance.
- R3: Active lanes of one load that read the identical word all receive that word. They add no pass beyond what distinct words require.
- R4: `rsp_passes` equals the largest number of distinct words requested in any single bank, with a minimum of 1. `rsp_done` rises exactly `rsp_passes` cycles after the accepting clock edge.
- R5: When several active lanes store to the same word in one request, the value of the highest-numbered of those lanes is kept.
- R6: Lanes with mask bit 0 take no part in conflict detection, write nothing and return zero. Stores return zero on all lanes.
- R7: After reset `req_ready` is 1 and `rsp_done` is 0. `req_ready` is 0 from the accepting edge until the cycle in which `rsp_done` is high, and it is 1 in that cycle.
- R8: A request with an all-zero mask completes in one pass and returns zero on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid is also high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mask | input | LANES | Per-lane active bit |
| req_addr | input | LANES x AW | Per-lane word address, AW = log2(BANKS*DEPTH) |
| req_wdata | input | LANES x DW | Per-lane store data |
| rsp_done | output | 1 | One-cycle pulse when the request has finished |
| rsp_rdata | output | LANES x DW | Per-lane load data, valid with `rsp_done` |
| rsp_passes | output | log2(LANES+1) | Number of passes the request used |

## Verification
Unit-stride traffic shows whether bank interleaving is right. It must finish in one pass, and a wrong bank/row split shows up as a bad readback. Strides of 2 and of a full bank count separate real conflicts from broadcasts. With a bank-count stride, every lane hits bank 0 and each word is shared by two lanes, so the pass count shows whether duplicate words are merged. All-same-word loads and stores, partly masked requests and empty masks isolate the broadcast rule, the highest-lane-wins store rule and mask exclusion. Random strides and dense random addresses in a small window, mixed with loads and stores, compare pass counts, latency and data against an independent model.

// File: rtl/bspad_pkg.sv
package bspad_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } bspad_state_e;

endpackage

// File: rtl/bspad_bank.sv
module bspad_bank #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 32,
   localparam int unsigned RW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [RW-1:0] row,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[row] <= wdata;
      end
   end

   // combinational read: the lane registers in the top sample it at the end of the pass
   assign rdata = mem[row];

endmodule

// File: rtl/bspad_select.sv
module bspad_select #(
   parameter int unsigned LANES = 32,
   parameter int unsigned BANKS = 32,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 32,
   localparam int unsigned BW   = $clog2(BANKS),
   localparam int unsigned RW   = $clog2(DEPTH),
   localparam int unsigned AW   = BW + RW
) (
   input  logic [LANES-1:0]          pend,
   input  logic [LANES-1:0][AW-1:0]  addr,
   input  logic [LANES-1:0][DW-1:0]  wdata,
   output logic [LANES-1:0]          served,
   output logic [BANKS-1:0]          bank_en,
   output logic [BANKS-1:0][RW-1:0]  bank_row,
   output logic [BANKS-1:0][DW-1:0]  bank_wdata
);

   logic [LANES-1:0] hit_b [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam int unsigned BIDX = b;
      logic              found;
      logic [AW-1:0]     sel;
      logic [LANES-1:0]  hit;
      logic [DW-1:0]     wd;

      always_comb begin
         found = 1'b0;
         sel   = '0;
         for (int l = 0; l < LANES; l++) begin
            if (!found && pend[l] && (addr[l][BW-1:0] == BW'(BIDX))) begin
               found = 1'b1;
               sel   = addr[l];
            end
         end
         hit = '0;
         wd  = '0;
         // ascending scan: the last matching lane leaves its data, so the highest lane wins
         for (int l = 0; l < LANES; l++) begin
            if (found && pend[l] && (addr[l] == sel)) begin
               hit[l] = 1'b1;
               wd     = wdata[l];
            end
         end
      end

      assign hit_b[b]      = hit;
      assign bank_en[b]    = found;
      assign bank_row[b]   = sel[AW-1:BW];
      assign bank_wdata[b] = wd;
   end

   always_comb begin
      served = '0;
      for (int b = 0; b < BANKS; b++) begin
         served = served | hit_b[b];
      end
   end

endmodule

// File: rtl/bspad_top.sv
module bspad_top #(
   parameter int unsigned LANES = 32,
   parameter int unsigned BANKS = 32,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 32,
   localparam int unsigned BW   = $clog2(BANKS),
   localparam int unsigned RW   = $clog2(DEPTH),
   localparam int unsigned AW   = BW + RW,
   localparam int unsigned PW   = $clog2(LANES + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic [LANES-1:0]          req_mask,
   input  logic [LANES-1:0][AW-1:0]  req_addr,
   input  logic [LANES-1:0][DW-1:0]  req_wdata,
   output logic                      rsp_done,
   output logic [LANES-1:0][DW-1:0]  rsp_rdata,
   output logic [PW-1:0]             rsp_passes
);
   import bspad_pkg::*;

   initial begin
      assert (BANKS >= 2 && (1 << BW) == BANKS)
         else $error("BANKS must be a power of two of at least 2");
      assert (DEPTH >= 2 && (1 << RW) == DEPTH)
         else $error("DEPTH must be a power of two of at least 2");
      assert (LANES >= 1) else $error("LANES must be at least 1");
      assert (DW >= 1) else $error("DW must be at least 1");
   end

   bspad_state_e              state;
   logic                      write_q;
   logic [LANES-1:0]          pend_q;
   logic [LANES-1:0][AW-1:0]  addr_q;
   logic [LANES-1:0][DW-1:0]  wdata_q;
   logic [LANES-1:0][DW-1:0]  rdata_q;
   logic [PW-1:0]             passes_q;
   logic                      done_q;

   logic [LANES-1:0]          served;
   logic [BANKS-1:0]          bank_en;
   logic [BANKS-1:0][RW-1:0]  bank_row;
   logic [BANKS-1:0][DW-1:0]  bank_wd;
   logic [BANKS-1:0][DW-1:0]  bank_rd;
   logic [LANES-1:0][DW-1:0]  lane_rd;
   logic [LANES-1:0]          pend_nxt;
   logic                      accept;
   logic                      running;

   assign req_ready  = (state == ST_IDLE);
   assign accept     = req_valid && req_ready;
   assign running    = (state == ST_RUN);
   assign pend_nxt   = pend_q & ~served;
   assign rsp_done   = done_q;
   assign rsp_rdata  = rdata_q;
   assign rsp_passes = passes_q;

   bspad_select #(
      .LANES(LANES), .BANKS(BANKS), .DEPTH(DEPTH), .DW(DW)
   ) u_select (
      .pend       (pend_q),
      .addr       (addr_q),
      .wdata      (wdata_q),
      .served     (served),
      .bank_en    (bank_en),
      .bank_row   (bank_row),
      .bank_wdata (bank_wd)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_mem
      bspad_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
         .clk   (clk),
         .we    (running && write_q && bank_en[b]),
         .row   (bank_row[b]),
         .wdata (bank_wd[b]),
         .rdata (bank_rd[b])
      );
   end

   // return crossbar: each lane takes the output of the bank its word lives in
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         lane_rd[l] = bank_rd[addr_q[l][BW-1:0]];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         write_q  <= 1'b0;
         pend_q   <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         passes_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state    <= ST_RUN;
            write_q  <= req_write;
            pend_q   <= req_mask;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            rdata_q  <= '0;
            passes_q <= '0;
         end else if (running) begin
            passes_q <= passes_q + PW'(1);
            pend_q   <= pend_nxt;
            for (int l = 0; l < LANES; l++) begin
               if (served[l] && !write_q) begin
                  rdata_q[l] <= lane_rd[l];
               end
            end
            if (pend_nxt == '0) begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/bspad_chk.sv
module bspad_chk #(
   parameter int unsigned LANES = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned PW    = 6
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic                      req_ready,
   input logic                      req_write,
   input logic [LANES-1:0]          req_mask,
   input logic                      rsp_done,
   input logic [LANES-1:0][DW-1:0]  rsp_rdata,
   input logic [PW-1:0]             rsp_passes
);

   logic [LANES-1:0]          mask_c;
   logic                      write_c;
   logic [15:0]               cnt;
   logic [LANES-1:0][DW-1:0]  leak;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_c  <= '0;
         write_c <= 1'b0;
         cnt     <= '0;
      end else if (req_valid && req_ready) begin
         mask_c  <= req_mask;
         write_c <= req_write;
         cnt     <= '0;
      end else if (!req_ready) begin
         cnt <= cnt + 16'd1;
      end
   end

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         leak[l] = (mask_c[l] && !write_c) ? '0 : rsp_rdata[l];
      end
   end

   a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r7_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);

   a_r4_latency_matches: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (cnt == 16'(rsp_passes)));

   a_r4_passes_floor: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (rsp_passes >= PW'(1)));

   a_r6_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (leak == '0));

   a_r2_single_lane_one_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && ($countones(mask_c) == 1)) |-> (rsp_passes == PW'(1)));

   a_r8_empty_one_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && (mask_c == '0)) |-> (rsp_passes == PW'(1)));

endmodule

bind bspad_top bspad_chk #(.LANES(LANES), .DW(DW), .PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .req_mask   (req_mask),
   .rsp_done   (rsp_done),
   .rsp_rdata  (rsp_rdata),
   .rsp_passes (rsp_passes)
);

// File: tb/bspad_top_bench.sv
module bspad_top_bench;

   localparam int LANES = 32;
   localparam int BANKS = 32;
   localparam int DEPTH = 16;
   localparam int DW    = 32;
   localparam int WORDS = BANKS * DEPTH;
   localparam int AW    = $clog2(WORDS);
   localparam int PW    = $clog2(LANES + 1);

   typedef logic [LANES-1:0][AW-1:0] addr_t;
   typedef logic [LANES-1:0][DW-1:0] data_t;

   typedef struct {
      data_t rd;
      int    passes;
      int    acc;
      string tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [LANES-1:0]  req_mask = '0;
   addr_t             req_addr = '0;
   data_t             req_wdata = '0;
   logic              rsp_done;
   data_t             rsp_rdata;
   logic [PW-1:0]     rsp_passes;

   int                errors = 0;
   int                checks = 0;
   int                cyc = 0;
   bit                finished = 0;
   logic [DW-1:0]     model [WORDS];
   exp_t              q [$];

   always #2.5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   bspad_top #(.LANES(LANES), .BANKS(BANKS), .DEPTH(DEPTH), .DW(DW)) u_bspad_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_mask   (req_mask),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .rsp_done   (rsp_done),
      .rsp_rdata  (rsp_rdata),
      .rsp_passes (rsp_passes)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic int exp_passes(input logic [LANES-1:0] m, input addr_t a);
      int best = 1;
      for (int b = 0; b < BANKS; b++) begin
         int n = 0;
         for (int l = 0; l < LANES; l++) begin
            if (m[l] && (int'(a[l]) % BANKS == b)) begin
               bit dup = 0;
               for (int j = 0; j < l; j++) begin
                  if (m[j] && a[j] == a[l]) dup = 1;
               end
               if (!dup) n++;
            end
         end
         if (n > best) best = n;
      end
      return best;
   endfunction

   task automatic send(input logic wr, input logic [LANES-1:0] m, input addr_t a,
                       input data_t d, input string tag);
      exp_t e;
      e.tag    = tag;
      e.passes = exp_passes(m, a);
      for (int l = 0; l < LANES; l++) begin
         e.rd[l] = (m[l] && !wr) ? model[a[l]] : '0;
      end
      if (wr) begin
         for (int l = 0; l < LANES; l++) begin
            if (m[l]) model[a[l]] = d[l];
         end
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_mask  = m;
      req_addr  = a;
      req_wdata = d;
      @(negedge clk);
      e.acc = cyc;
      q.push_back(e);
      req_valid = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_done) begin
         if (q.size() == 0) begin
            check(0, "R7 unexpected done", 1, 0);
         end else begin
            exp_t e;
            int bad;
            e = q.pop_front();
            check(int'(rsp_passes) == e.passes, {e.tag, " R4 passes"}, rsp_passes, e.passes);
            check(cyc - e.acc == e.passes, {e.tag, " R4 latency"}, cyc - e.acc, e.passes);
            bad = -1;
            for (int l = LANES - 1; l >= 0; l--) begin
               if (rsp_rdata[l] !== e.rd[l]) bad = l;
            end
            if (bad >= 0)
               check(0, $sformatf("%s data lane %0d", e.tag, bad), rsp_rdata[bad], e.rd[bad]);
            else
               check(1, e.tag, 0, 0);
         end
      end
   end

   function automatic logic [DW-1:0] pat(input int w);
      return 32'hA500_0000 ^ (w * 32'h0000_9E37);
   endfunction

   initial begin
      addr_t a;
      data_t d;
      logic [LANES-1:0] m;
      repeat (3) @(negedge clk);
      check(req_ready === 1'b1, "R7 reset ready", req_ready, 1);
      check(rsp_done === 1'b0, "R7 reset done", rsp_done, 0);
      rst_n = 1'b1;

      // R1 R2: fill memory with consecutive words
      for (int r = 0; r < WORDS / LANES; r++) begin
         for (int l = 0; l < LANES; l++) begin
            a[l] = AW'(r * LANES + l);
            d[l] = pat(r * LANES + l);
         end
         send(1'b1, '1, a, d, "R2 fill store");
      end
      // R1 R2: consecutive loads
      for (int r = 0; r < WORDS / LANES; r++) begin
         for (int l = 0; l < LANES; l++) a[l] = AW'(r * LANES + l);
         send(1'b0, '1, a, '0, "R1 R2 unit stride load");
      end
      // R4: stride 2, two words per bank
      for (int l = 0; l < LANES; l++) a[l] = AW'(2 * l);
      send(1'b0, '1, a, '0, "R4 stride two");
      // R3 R4: stride of bank count, 16 distinct words in bank 0, each shared by two lanes
      for (int l = 0; l < LANES; l++) a[l] = AW'((l * BANKS) % WORDS);
      send(1'b0, '1, a, '0, "R3 R4 bank stride");
      // R3: all lanes read one word
      for (int l = 0; l < LANES; l++) a[l] = AW'(77);
      send(1'b0, '1, a, '0, "R3 broadcast");
      // R5: all lanes store one word, then read it back
      for (int l = 0; l < LANES; l++) begin
         a[l] = AW'(7);
         d[l] = 32'h1000 + l;
      end
      send(1'b1, '1, a, d, "R5 same word store");
      send(1'b0, '1, a, '0, "R5 readback all");
      // R5 R6: top lane masked off, its data must not land
      d[LANES-1] = 32'hDEAD;
      m = '1;
      m[LANES-1] = 1'b0;
      send(1'b1, m, a, d, "R5 R6 masked top lane store");
      send(1'b0, '1, a, '0, "R5 R6 readback");
      // R6: conflicts only among inactive lanes
      for (int l = 0; l < LANES; l++) a[l] = (l % 2 == 0) ? AW'(l) : AW'(l + 64);
      m = '0;
      for (int l = 0; l < LANES; l += 2) m[l] = 1'b1;
      for (int l = 1; l < LANES; l += 2) a[l] = AW'(0);
      send(1'b0, m, a, '0, "R6 inactive conflicts ignored");
      // R8: empty mask
      send(1'b0, '0, a, '0, "R8 empty load");
      send(1'b1, '0, a, d, "R8 empty store");
      send(1'b0, '1, a, '0, "R8 R6 memory untouched");

      // R4: random strides and dense random windows, back to back
      for (int t = 0; t < 120; t++) begin
         int stride;
         int base;
         int sel;
         sel    = $urandom_range(0, 7);
         base   = $urandom_range(0, WORDS - 1);
         case (sel)
            0: stride = 1;  1: stride = 2;  2: stride = 3;  3: stride = 4;
            4: stride = 8;  5: stride = 16; 6: stride = 33; default: stride = 32;
         endcase
         for (int l = 0; l < LANES; l++) begin
            if (t % 3 == 2) a[l] = AW'($urandom_range(0, 127));
            else            a[l] = AW'((base + l * stride) % WORDS);
            d[l] = $urandom;
         end
         m = (t % 4 == 0) ? '1 : LANES'($urandom);
         send(1'($urandom_range(0, 1)), m, a, d, "R4 R1 random pattern");
      end

      repeat (40) @(negedge clk);
      check(q.size() == 0, "R7 all responses seen", q.size(), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog R7: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule